// File: doc/BRIEF.md
# Selectable-Length Periodic Interrupt Divider

This block divides a slow sub-oscillator clock with a binary up-counter and raises a periodic interrupt flag each time the counter overflows. A length select picks the short range (2^SHORT_W counts, 8192 by default) or the long range (twice that, 16384 by default). With a 32768 Hz sub-clock this gives an interrupt every 0.25 s or every 0.5 s. While the run enable is low, the counter is held at zero and does not count. Raising the enable starts a full period from zero.

The counter lives in the sub-clock domain. Each overflow flips a toggle bit. A synchroniser carries that toggle into the CPU clock domain, where an edge detector turns each flip into a single set pulse for a sticky flag. Software clears the flag through a clear strobe, and the interrupt controller clears it through an acknowledge strobe. A set arriving in the same cycle as a clear wins.

Top module: `periodic_divider`

## Requirements
- R1: After reset, `div_flag` is 0 and the counter is at zero.
- R2: With `run_en` high and `long_sel` low, an overflow occurs on every 2^SHORT_W-th enabled sub-clock edge counted from zero. On the overflow edge the counter returns to zero.
- R3: With `long_sel` high (1 = long range), an overflow occurs on every 2^(SHORT_W+1)-th enabled sub-clock edge counted from zero.
- R4: While `run_en` is 0 at a sub-clock edge, the counter is forced to zero and no overflow occurs. After `run_en` returns to 1, a full period counted from zero elapses before the next overflow.
- R5: Changing `long_sel` while the counter runs keeps the count. In short mode the counter overflows when its low SHORT_W bits are all ones, even if the top bit is set. In long mode it overflows when all SHORT_W+1 bits are ones.
- R6: `div_flag` stays at its value in any CPU cycle that has no set pulse, no `sw_clear` and no `irq_ack`.
- R7: `sw_clear` high at a CPU edge with no coincident set clears `div_flag` at that edge.
- R8: `irq_ack` high at a CPU edge with no coincident set clears `div_flag` at that edge.
- R9: A set pulse at the same CPU edge as `sw_clear` or `irq_ack` leaves `div_flag` at 1.
- R10: Each overflow sets `div_flag` exactly once. With SYNC_STAGES = 2 and the clocks edge-aligned, the flag rises at the third CPU edge after the sub-clock edge that overflowed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sub_clk | input | 1 | Sub-oscillator clock that drives the counter |
| sub_rst_n | input | 1 | Asynchronous active-low reset, sub-clock domain |
| run_en | input | 1 | 1 = count, 0 = hold the counter at zero (sampled on sub_clk) |
| long_sel | input | 1 | 0 = short range, 1 = long range (sampled on sub_clk) |
| cpu_clk | input | 1 | CPU clock for the flag logic |
| cpu_rst_n | input | 1 | Asynchronous active-low reset, CPU domain |
| sw_clear | input | 1 | Software clear strobe for the flag |
| irq_ack | input | 1 | Interrupt-service clear strobe for the flag |
| div_flag | output | 1 | Sticky overflow interrupt flag, CPU domain |

## Verification
An overflow is due on the sub-clock edge at which the bench's own counter model reaches its limit. The flag that follows is due three CPU edges later: one edge for each synchroniser stage and one for the flag register. A clear strobe takes effect at the CPU edge that samples it. The bench runs a cycle-exact model that advances at every CPU posedge, moves the sub-clock part only on the edges where the clocks coincide, and compares `div_flag` with the model at every CPU falling edge. Each result is therefore checked in exactly the cycle it is due, never a cycle early or late.

// File: rtl/div_pkg.sv
package div_pkg;
    localparam int DEF_SHORT_W     = 13;
    localparam int DEF_SYNC_STAGES = 2;

    typedef struct packed {
        logic flag;
    } flag_state_t;
endpackage

// File: rtl/div_counter.sv
module div_counter #(
    parameter int SHORT_W = div_pkg::DEF_SHORT_W,
    localparam int LONG_W = SHORT_W + 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_en,
    input  logic long_sel,
    output logic wrap_tog
);
    typedef struct packed {
        logic [LONG_W-1:0] cnt;
        logic              tog;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic       low_full;
    logic       at_limit;

    always_comb begin
        st_d     = st_q;
        low_full = &st_q.cnt[SHORT_W-1:0];
        at_limit = low_full && (!long_sel || st_q.cnt[LONG_W-1]);
        if (!run_en) begin
            st_d.cnt = '0;
        end else if (at_limit) begin
            st_d.cnt = '0;
            st_d.tog = ~st_q.tog;
        end else begin
            st_d.cnt = st_q.cnt + LONG_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wrap_tog = st_q.tog;

    assert_hold_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (st_q.cnt == '0));
    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !(&st_q.cnt[SHORT_W-1:0])) |=> (st_q.cnt == $past(st_q.cnt) + LONG_W'(1)));
    assert_wrap_to_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.tog != $past(st_q.tog)) |-> (st_q.cnt == '0));
    assert_no_wrap_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> $stable(st_q.tog));
endmodule

// File: rtl/div_flag_sync.sv
module div_flag_sync #(
    parameter int SYNC_STAGES = div_pkg::DEF_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tog_in,
    output logic set_pulse
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] chain;
        logic                   last;
    } sync_state_t;

    sync_state_t st_d, st_q;
    logic [SYNC_STAGES-1:0] shift_in;

    assign shift_in[0] = tog_in;
    for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_stage
        assign shift_in[g] = st_q.chain[g-1];
    end

    always_comb begin
        st_d       = st_q;
        st_d.chain = shift_in;
        st_d.last  = st_q.chain[SYNC_STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign set_pulse = st_q.chain[SYNC_STAGES-1] ^ st_q.last;

    assert_edge_once_R10: assert property (@(posedge clk) disable iff (!rst_n)
        set_pulse |=> (st_q.last == $past(st_q.chain[SYNC_STAGES-1])));
endmodule

// File: rtl/div_flag_reg.sv
module div_flag_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic set_pulse,
    input  logic sw_clear,
    input  logic irq_ack,
    output logic flag
);
    import div_pkg::*;

    flag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_pulse)              st_d.flag = 1'b1;
        else if (sw_clear || irq_ack) st_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag = st_q.flag;

    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        set_pulse |=> flag);
    assert_clear_sw_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_clear && !set_pulse) |=> !flag);
    assert_clear_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !set_pulse) |=> !flag);
    assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_pulse && !sw_clear && !irq_ack) |=> $stable(flag));
endmodule

// File: rtl/periodic_divider.sv
module periodic_divider #(
    parameter int SHORT_W     = div_pkg::DEF_SHORT_W,
    parameter int SYNC_STAGES = div_pkg::DEF_SYNC_STAGES
) (
    input  logic sub_clk,
    input  logic sub_rst_n,
    input  logic run_en,
    input  logic long_sel,
    input  logic cpu_clk,
    input  logic cpu_rst_n,
    input  logic sw_clear,
    input  logic irq_ack,
    output logic div_flag
);
    logic wrap_tog;
    logic set_pulse;

    div_counter #(.SHORT_W(SHORT_W)) u_counter (
        .clk      (sub_clk),
        .rst_n    (sub_rst_n),
        .run_en   (run_en),
        .long_sel (long_sel),
        .wrap_tog (wrap_tog)
    );

    div_flag_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk       (cpu_clk),
        .rst_n     (cpu_rst_n),
        .tog_in    (wrap_tog),
        .set_pulse (set_pulse)
    );

    div_flag_reg u_flag (
        .clk       (cpu_clk),
        .rst_n     (cpu_rst_n),
        .set_pulse (set_pulse),
        .sw_clear  (sw_clear),
        .irq_ack   (irq_ack),
        .flag      (div_flag)
    );

    assert_reset_low_R1: assert property (@(posedge cpu_clk) !cpu_rst_n |=> !div_flag);
endmodule

// File: tb/periodic_divider_test.sv
module periodic_divider_test;
    localparam int SW = 4;
    localparam int LW = SW + 1;

    logic sub_clk = 1'b0, cpu_clk = 1'b0;
    logic sub_rst_n = 1'b0, cpu_rst_n = 1'b0;
    logic run_en = 1'b0, long_sel = 1'b0, sw_clear = 1'b0, irq_ack = 1'b0;
    logic div_flag;

    int checks = 0, failures = 0;
    int idx = 0;
    bit active = 0;
    string tag = "R1";

    // bench model state
    logic [LW-1:0] m_cnt = '0;
    logic m_tog = 1'b0, m_s1 = 1'b0, m_s2 = 1'b0, m_s3 = 1'b0, m_flag = 1'b0;
    int m_sets = 0;

    periodic_divider #(.SHORT_W(SW), .SYNC_STAGES(2)) uut (
        .sub_clk(sub_clk), .sub_rst_n(sub_rst_n), .run_en(run_en), .long_sel(long_sel),
        .cpu_clk(cpu_clk), .cpu_rst_n(cpu_rst_n), .sw_clear(sw_clear), .irq_ack(irq_ack),
        .div_flag(div_flag)
    );

    always #10 cpu_clk = ~cpu_clk;
    initial begin
        #10;
        forever begin sub_clk = 1'b1; #40; sub_clk = 1'b0; #40; end
    end

    function automatic bit limit_hit(logic [LW-1:0] c, logic lsel);
        return (&c[SW-1:0]) && (!lsel || c[LW-1]);
    endfunction

    always @(posedge cpu_clk) begin
        logic old_tog, old_s2, old_s3;
        old_tog = m_tog; old_s2 = m_s2; old_s3 = m_s3;
        if (idx % 4 == 0) begin
            if (!sub_rst_n) begin m_cnt = '0; m_tog = 1'b0; end
            else if (!run_en) m_cnt = '0;
            else if (limit_hit(m_cnt, long_sel)) begin m_cnt = '0; m_tog = ~m_tog; end
            else m_cnt = m_cnt + 1'b1;
        end
        if (!cpu_rst_n) begin
            m_s1 = 0; m_s2 = 0; m_s3 = 0; m_flag = 0;
        end else begin
            if (old_s2 ^ old_s3) begin m_flag = 1'b1; m_sets++; end
            else if (sw_clear || irq_ack) m_flag = 1'b0;
            m_s3 = old_s2; m_s2 = m_s1; m_s1 = old_tog;
        end
        idx++;
    end

    task automatic check(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            if (failures < 20)
                $display("FAIL %s div_flag actual=%0b expected=%0b at idx %0d", req, act, exp, idx);
        end
    endtask

    always @(negedge cpu_clk) if (active) check(tag, div_flag, m_flag);

    task automatic cyc(int n);
        repeat (n) @(negedge cpu_clk);
    endtask

    task automatic pulse_clear(bit use_ack);
        if (use_ack) irq_ack = 1'b1; else sw_clear = 1'b1;
        cyc(1);
        irq_ack = 1'b0; sw_clear = 1'b0;
    endtask

    initial begin
        bit done;
        void'($urandom(32'd2024));
        cyc(3);
        check("R1", div_flag, 1'b0);
        sub_rst_n = 1'b1; cpu_rst_n = 1'b1;
        cyc(1);
        check("R1", div_flag, 1'b0);
        active = 1;

        // R2: short range, several periods, flag sticky between (R6)
        tag = "R2"; run_en = 1'b1; long_sel = 1'b0;
        cyc(4 * 16 * 3 + 8);
        tag = "R6"; cyc(10);
        tag = "R7"; pulse_clear(0); cyc(5);
        check("R7", div_flag, 1'b0);

        // R3: long range
        tag = "R3"; long_sel = 1'b1;
        cyc(4 * 32 * 2 + 8);
        tag = "R8"; pulse_clear(1); cyc(5);
        check("R8", div_flag, 1'b0);

        // R4: disable mid-count, restart from zero
        tag = "R4"; cyc(4 * 10);
        run_en = 1'b0; cyc(4 * 50);
        run_en = 1'b1; pulse_clear(0);
        cyc(4 * 40);

        // R5: long -> short switch with top bit set
        tag = "R5"; pulse_clear(1);
        run_en = 1'b0; cyc(8); run_en = 1'b1; long_sel = 1'b1;
        cyc(4 * 20);
        long_sel = 1'b0;
        cyc(4 * 40);
        long_sel = 1'b1; cyc(4 * 8); long_sel = 1'b0; cyc(4 * 20);

        // R9: clear held high across sets
        tag = "R9"; sw_clear = 1'b1; cyc(4 * 40); sw_clear = 1'b0;
        irq_ack = 1'b1; cyc(4 * 40); irq_ack = 1'b0;

        // R10: set count matches overflow count
        tag = "R10"; cyc(4 * 40);
        checks++;
        if (m_sets < 10) begin
            failures++;
            $display("FAIL R10 set count actual=%0d expected>=10", m_sets);
        end

        // random mix
        tag = "R6";
        for (int i = 0; i < 4000; i++) begin
            if ($urandom % 60 == 0) run_en = ~run_en;
            if ($urandom % 80 == 0) long_sel = ~long_sel;
            sw_clear = ($urandom % 25 == 0);
            irq_ack  = ($urandom % 25 == 0);
            cyc(1);
        end
        sw_clear = 0; irq_ack = 0; cyc(2);
        active = 0;
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(20 * 150000);
        failures++; checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule